// File: doc/BRIEF.md
# Virtual-Output-Queue Round-Robin Header Scheduler

This block sits between the traffic sources of a small code-division on-chip switch and the spreading-code lookups. Every input presents a 6-bit header holding a source address and a destination address. The block files each accepted header into a small FIFO kept for that exact (input, output) pair. A header waiting for a congested output therefore never holds back headers behind it that are bound elsewhere.

Each output runs its own rotating-priority arbiter over the inputs whose queue for that output is non-empty, and grants at most one per cycle. The granted header is split into its two address fields. The source field drives the code selector on the transmit side and the destination field drives the code selector on the receive side, both registered per output. An input can give up only one header per cycle. When several outputs pick the same input, the lowest-numbered output takes it and the others stay idle for that cycle.

Top module: `vocq_sched`

## Requirements
- R1: A header uses bits [5:3] as the source address and bits [2:0] as the destination address. An accepted header on input i lands in queue (i, dst). When it is granted, output dst shows `tx_src` equal to the header's source field and `rx_dst` equal to the header's destination field.
- R2: Every (input, output) pair owns a FIFO that is DEPTH (default 4) deep. `in_ready[i]` is low exactly when the queue selected by the destination field on input i is full. A header presented while `in_ready` is low is discarded and never granted.
- R3: A backlog on input i for one output does not delay a header from input i to another, idle output. That header is granted one cycle after it is accepted.
- R4: Each output keeps a pointer. The search for a non-empty queue starts at the input the pointer names and moves upward, wrapping past the highest input. After a grant the pointer moves to the input just after the one granted. All pointers are 0 after reset.
- R5: When only one input has a header for an output, that input is granted at once, whatever the pointer's value.
- R6: An input gives up at most one header per cycle. When it is picked by several outputs, the lowest-numbered output is granted. The other outputs give no grant that cycle and keep their pointers.
- R7: A header accepted at clock edge k into an empty queue, with no contention, appears with `out_valid` high after edge k+1. `out_valid` lasts one cycle per grant.
- R8: While `rst` is high, `out_valid` is 0, all queues are empty (so `in_ready` is all ones) and all pointers are 0.
- R9: Headers in one queue are granted in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 2**AW | Per-input header valid |
| in_hdr | input | 2**AW*2*AW | Per-input header, input i at bits [i*2*AW +: 2*AW] |
| in_ready | output | 2**AW | Per-input: queue for the presented destination has room |
| out_valid | output | 2**AW | Per-output grant for this cycle |
| tx_src | output | 2**AW*AW | Per-output granted source address, to the transmit code selector |
| rx_dst | output | 2**AW*AW | Per-output granted destination address, to the receive code selector |

## Verification
The arbitration is tried with four kinds of input pattern. Three inputs piling onto one output show whether the pointer rotates. Two outputs served in parallel show whether the outputs arbitrate independently. One input picked by two outputs at once shows the lowest-output rule and the held pointer. Two inputs interleaving distinct headers into one output show round-robin alternation and FIFO order. A sustained two-into-one overload fills the queues. It separates refusal from silent loss by comparing accepted headers with grants. During that overload a single header to another output shows whether head-of-line blocking is absent.

// File: rtl/vocq_sched.sv
module vocq_sched #(
  parameter int AW    = 3,
  parameter int DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [(1<<AW)-1:0]        in_valid,
  input  logic [(1<<AW)*2*AW-1:0]   in_hdr,
  output logic [(1<<AW)-1:0]        in_ready,
  output logic [(1<<AW)-1:0]        out_valid,
  output logic [(1<<AW)*AW-1:0]     tx_src,
  output logic [(1<<AW)*AW-1:0]     rx_dst
);
  localparam int NP = 1 << AW;
  localparam int HW = 2 * AW;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [HW-1:0] mem  [NP][NP][DEPTH];
  logic [PW-1:0] wp   [NP][NP];
  logic [PW-1:0] rp   [NP][NP];
  logic [CW-1:0] cnt  [NP][NP];
  logic [AW-1:0] rr   [NP];
  logic [AW-1:0] pick [NP];
  logic [HW-1:0] head [NP];
  logic [NP-1:0] pick_v, win;
  logic [NP-1:0] push [NP];
  logic [NP-1:0] pop  [NP];
  logic [AW-1:0] in_dst [NP];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < NP; i++) begin : g_in
    assign in_dst[i]   = in_hdr[i*HW +: AW];
    assign in_ready[i] = cnt[i][in_dst[i]] != CW'(DEPTH);
    assign push[i]     = (in_valid[i] && in_ready[i]) ? (NP'(1) << in_dst[i]) : '0;
  end

  always_comb begin
    logic [AW-1:0] idx;
    for (int o = 0; o < NP; o++) begin
      pick_v[o] = 1'b0;
      pick[o]   = rr[o];
      for (int k = NP - 1; k >= 0; k--) begin
        idx = rr[o] + AW'(k);
        if (cnt[idx][o] != '0) begin
          pick_v[o] = 1'b1;
          pick[o]   = idx;
        end
      end
      head[o] = mem[pick[o]][o][rp[pick[o]][o]];
    end
  end

  always_comb begin
    win = pick_v;
    for (int o = 1; o < NP; o++)
      for (int q = 0; q < o; q++)
        if (pick_v[q] && pick[q] == pick[o]) win[o] = 1'b0;
    for (int i = 0; i < NP; i++) pop[i] = '0;
    for (int o = 0; o < NP; o++)
      if (win[o]) pop[pick[o]][o] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++)
      for (int o = 0; o < NP; o++)
        if (push[i][o]) mem[i][o][wp[i][o]] <= in_hdr[i*HW +: HW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NP; i++)
        for (int o = 0; o < NP; o++) begin
          wp[i][o]  <= '0;
          rp[i][o]  <= '0;
          cnt[i][o] <= '0;
        end
    end else begin
      for (int i = 0; i < NP; i++)
        for (int o = 0; o < NP; o++) begin
          if (push[i][o]) wp[i][o] <= bump(wp[i][o]);
          if (pop[i][o])  rp[i][o] <= bump(rp[i][o]);
          cnt[i][o] <= cnt[i][o] + CW'(push[i][o]) - CW'(pop[i][o]);
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= '0;
      tx_src    <= '0;
      rx_dst    <= '0;
      for (int o = 0; o < NP; o++) rr[o] <= '0;
    end else begin
      out_valid <= win;
      for (int o = 0; o < NP; o++)
        if (win[o]) begin
          rr[o]               <= pick[o] + AW'(1);
          tx_src[o*AW +: AW]  <= head[o][HW-1:AW];
          rx_dst[o*AW +: AW]  <= head[o][AW-1:0];
        end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_chk_in
    AST_ONE_POP: assert property (@(posedge clk) disable iff (rst) $onehot0(pop[i])); // R6
    for (genvar o = 0; o < NP; o++) begin : g_chk_pair
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt[i][o] <= CW'(DEPTH)); // R2
      AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid[i] && in_dst[i] == AW'(o) && cnt[i][o] == CW'(DEPTH) && !pop[i][o])
        |=> cnt[i][o] == CW'(DEPTH)); // R2
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk_out
    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      win[o] |=> rr[o] == $past(pick[o]) + AW'(1)); // R4
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !win[o] |=> $stable(rr[o])); // R6
    AST_DST_MATCH: assert property (@(posedge clk) disable iff (rst)
      out_valid[o] |-> rx_dst[o*AW +: AW] == AW'(o)); // R1
  end
endmodule

// File: tb/sim_vocq_sched.sv
module sim_vocq_sched;
  localparam int PERIOD = 10;
  localparam int AW = 3;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] in_valid;
  logic [NP*6-1:0] in_hdr;
  logic [NP-1:0] in_ready, out_valid;
  logic [NP*3-1:0] tx_src, rx_dst;

  vocq_sched #(.AW(AW), .DEPTH(4)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_hdr(in_hdr), .in_ready(in_ready),
    .out_valid(out_valid), .tx_src(tx_src), .rx_dst(rx_dst));

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // [63:56] valid, [55:32] dst per input, [31:24] expected grants, [23:0] expected src per output
  localparam logic [63:0] VEC [9] = '{
    {8'h07, 24'h000000, 8'h00, 24'h000000},
    {8'h09, 24'h000201, 8'h01, 24'h000000},
    {8'h00, 24'h000000, 8'h03, 24'h000001},
    {8'h00, 24'h000000, 8'h03, 24'h00001A},
    {8'h30, 24'h012000, 8'h00, 24'h000000},
    {8'h20, 24'h018000, 8'h04, 24'h000100},
    {8'h00, 24'h000000, 8'h04, 24'h000140},
    {8'h00, 24'h000000, 8'h08, 24'h000A00},
    {8'h00, 24'h000000, 8'h00, 24'h000000}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] hdr(input int s, input int d);
    return {3'(s), 3'(d)};
  endfunction

  task automatic idle();
    in_valid = '0;
    in_hdr   = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int acc, g7;
    bit saw_full;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == '0, "R8 out_valid in reset", out_valid, 0);
    check(in_ready == '1, "R8 queues empty in reset", in_ready, 8'hFF);
    rst = 1'b0;

    // Table: rotation, parallel outputs, sole requester, lowest-output conflict
    for (int k = 0; k < 9; k++) begin
      logic [7:0] gv;
      logic [23:0] es;
      bit ok;
      in_valid = VEC[k][63:56];
      for (int i = 0; i < NP; i++) in_hdr[i*6 +: 6] = hdr(i, int'(VEC[k][32 + i*3 +: 3]));
      gv = VEC[k][31:24];
      es = VEC[k][23:0];
      step();
      ok = (out_valid == gv);
      for (int o = 0; o < NP; o++)
        if (gv[o] && (tx_src[o*3 +: 3] != es[o*3 +: 3] || rx_dst[o*3 +: 3] != 3'(o))) ok = 1'b0;
      check(ok, $sformatf("R1 R4 R5 R6 R7 vector %0d (grants/src)", k),
            int'({out_valid, tx_src}), int'({gv, es}));
    end
    idle();

    // R9 and R4: two inputs interleave into output 5
    begin
      int exp_src [6] = '{1, 5, 2, 6, 3, 7};
      for (int j = 0; j < 3; j++) begin
        in_valid = 8'h06;
        in_hdr[1*6 +: 6] = hdr(1 + j, 5);
        in_hdr[2*6 +: 6] = hdr(5 + j, 5);
        step();
        if (j == 0) check(out_valid == '0, "R7 no grant before queue seen", out_valid, 0);
        else check(out_valid == 8'h20 && tx_src[15 +: 3] == 3'(exp_src[j-1]),
                   "R9 R4 order on output 5", int'(tx_src[15 +: 3]), exp_src[j-1]);
      end
      idle();
      for (int j = 2; j < 6; j++) begin
        step();
        check(out_valid == 8'h20 && tx_src[15 +: 3] == 3'(exp_src[j]) && rx_dst[15 +: 3] == 3'd5,
              "R9 R4 order on output 5", int'(tx_src[15 +: 3]), exp_src[j]);
      end
      step();
      check(out_valid == '0, "R7 grants stop when drained", out_valid, 0);
    end

    // R2 and R3: overload output 7, then a header from the same input to output 4
    acc = 0;
    g7 = 0;
    saw_full = 1'b0;
    for (int c = 0; c < 12; c++) begin
      in_valid = 8'hC0;
      in_hdr[6*6 +: 6] = hdr(6, 7);
      in_hdr[7*6 +: 6] = hdr(7, 7);
      #1;
      acc += int'(in_ready[6]) + int'(in_ready[7]);
      if (!in_ready[6] || !in_ready[7]) saw_full = 1'b1;
      step();
      if (out_valid[7]) g7++;
    end
    check(saw_full, "R2 backpressure under overload", int'(saw_full), 1);
    idle();
    in_valid = 8'h40;
    in_hdr[6*6 +: 6] = hdr(6, 4);
    #1;
    check(in_ready[6], "R3 other queue of blocked input has room", int'(in_ready[6]), 1);
    step();
    if (out_valid[7]) g7++;
    idle();
    step();
    if (out_valid[7]) g7++;
    check(out_valid[4] && tx_src[12 +: 3] == 3'd6 && rx_dst[12 +: 3] == 3'd4,
          "R3 no head-of-line blocking on output 4", int'({out_valid[4], tx_src[12 +: 3]}), 'hE);
    for (int c = 0; c < 20; c++) begin
      step();
      if (out_valid[7]) g7++;
    end
    check(g7 == acc, "R2 refused headers dropped, accepted all granted", g7, acc);
    check(in_ready == '1 && out_valid == '0, "R2 queues drained", int'({in_ready, out_valid}), 'hFF00);

    finish_run();
  end
endmodule